// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A memory controller loads it with a start column, a length code and an ordering choice when it issues a column command. On each following clock the block presents one column address, a flag that a burst is running, and a flag that marks the final beat. The controller can cut a burst short with a stop strobe. It can also replace the running burst at any clock with a fresh column command. The replacement burst starts on the very next cycle with no idle gap, so column commands may be issued on every clock.

Two orderings are offered. Sequential ordering counts upward inside an aligned block the size of the burst and wraps inside that block. Interleaved ordering flips the low address bits with a beat counter. A full-page length runs sequentially across all columns of a row, wrapping at the top, until it is stopped or replaced. Full page cannot be combined with interleaving. If that combination is requested, the block runs an 8-beat interleaved burst instead and raises an error flag for the length of that burst.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset, and whenever no burst is running, `burst_act_o` = 0, `col_o` = 0, `last_beat_o` = 0 and `cfg_err_o` = 0.
- R2: On the clock after a cycle with `start_i` = 1, `burst_act_o` = 1 and `col_o` equals the `start_col_i` sampled with the strobe.
- R3: Length codes on `len_i` are 0 = 1 beat, 1 = 2 beats, 2 = 4 beats and 3 = 8 beats. A burst of L beats holds `burst_act_o` high for exactly L cycles, and `last_beat_o` is high only on the L-th beat. The block is idle on the following cycle unless a new start arrives.
- R4: Sequential ordering (`ilv_i` = 0): beat k (counted from 0) has address (S & ~(L-1)) | ((S + k) mod L), where S is the start column.
- R5: Interleaved ordering (`ilv_i` = 1, L ≤ 8): beat k has address S XOR k.
- R6: Length code 7 with sequential ordering is full page. Beat k has address (S + k) mod 256, so column 255 is followed by 0. `last_beat_o` stays 0 and the burst continues until it is stopped or replaced.
- R7: `stop_i` = 1 without `start_i` ends a running burst. On the next cycle `burst_act_o` = 0.
- R8: `start_i` during a running burst restarts the sequence on the next cycle from the new start column with no idle cycle. If `start_i` and `stop_i` are high together, the start wins.
- R9: Length code 7 together with `ilv_i` = 1 runs as an 8-beat interleaved burst, with `cfg_err_o` = 1 on every beat of it.
- R10: The unused length codes 4, 5 and 6 behave as a 1-beat burst.
- R11: `stop_i` while idle has no effect; the outputs stay at their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe: load a new burst |
| start_col_i | input | COL_W (8) | Start column sampled with `start_i` |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| stop_i | input | 1 | Burst stop strobe |
| col_o | output | COL_W (8) | Column address of the current beat |
| burst_act_o | output | 1 | A beat is being presented this cycle |
| last_beat_o | output | 1 | Current beat is the final beat of the burst |
| cfg_err_o | output | 1 | Current burst used the illegal interleave/full-page combination |

## Verification
Every result is due exactly one clock after the edge that samples the strobe. The first beat appears on the cycle after `start_i`, each later beat one cycle after the previous one, and the idle state one cycle after a stop or after the last beat. The bench applies inputs on the falling edge and steps a reference model at each rising edge. It compares all four outputs shortly after that rising edge, so every check lands in the cycle where the registered result has just changed. Stimulus covers aligned and unaligned starts, wrap at column 255, interruptions on the first, middle and last beats, start and stop together, and stops while idle.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

   // length codes on the len input
   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   // number of low address bits an 8-beat burst spans
   localparam int unsigned SPAN_8 = 3;

   // low-bit span for a code; page_bits is the full column width
   function automatic int unsigned span_of(input logic [2:0] code,
                                           input logic       ilv,
                                           input int unsigned page_bits);
      int unsigned s;
      case (code)
         LEN_2:    s = 1;
         LEN_4:    s = 2;
         LEN_8:    s = SPAN_8;
         LEN_PAGE: s = ilv ? SPAN_8 : page_bits;
         default:  s = 0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/col_burst_decode.sv
module col_burst_decode
   import col_burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [2:0]       len_code,
   input  logic             ilv,
   output logic [COL_W-1:0] mask,
   output logic             page,
   output logic             bad_cfg
);

   localparam int unsigned SPAN_W = $clog2(COL_W + 1);

   logic [SPAN_W-1:0] span;

   always_comb begin
      span    = SPAN_W'(span_of(len_code, ilv, COL_W));
      page    = (len_code == LEN_PAGE) && !ilv;
      bad_cfg = (len_code == LEN_PAGE) && ilv;
   end

   // one comparator per address bit builds the wrap mask
   for (genvar b = 0; b < COL_W; b++) begin : g_mask
      assign mask[b] = (SPAN_W'(b) < span);
   end

endmodule

// File: rtl/col_burst_state.sv
module col_burst_state #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] col_in,
   input  logic             ilv_in,
   input  logic [COL_W-1:0] mask_in,
   input  logic             page_in,
   input  logic             bad_in,
   output logic             act,
   output logic [COL_W-1:0] beat,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] mask,
   output logic             ilv,
   output logic             bad,
   output logic             last
);

   logic page;

   assign last = act && !page && (beat == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         beat <= '0;
         base <= '0;
         mask <= '0;
         ilv  <= 1'b0;
         page <= 1'b0;
         bad  <= 1'b0;
      end else if (start) begin
         act  <= 1'b1;
         beat <= '0;
         base <= col_in;
         mask <= mask_in;
         ilv  <= ilv_in;
         page <= page_in;
         bad  <= bad_in;
      end else if (stop) begin
         act  <= 1'b0;
      end else if (act) begin
         if (last) act <= 1'b0;
         beat <= beat + 1'b1;
      end
   end

endmodule

// File: rtl/col_burst_addr.sv
module col_burst_addr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             act,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] sum;

   assign sum = base + beat;

   // bits inside the mask move; bits above keep the start column
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      logic moved;
      assign moved  = ilv ? (base[b] ^ beat[b]) : sum[b];
      assign col[b] = act && (mask[b] ? moved : base[b]);
   end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
   import col_burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_i,
   input  logic             ilv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             burst_act_o,
   output logic             last_beat_o,
   output logic             cfg_err_o
);

   if (COL_W < SPAN_8 || COL_W > 16) begin : g_bad_width
      $error("COL_W must lie between 3 and 16");
   end

   logic [COL_W-1:0] d_mask, r_mask, r_base, r_beat;
   logic             d_page, d_bad, r_ilv, r_bad, r_act, r_last;

   col_burst_decode #(.COL_W(COL_W)) u_decode (
      .len_code (len_i),
      .ilv      (ilv_i),
      .mask     (d_mask),
      .page     (d_page),
      .bad_cfg  (d_bad)
   );

   col_burst_state #(.COL_W(COL_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .stop    (stop_i),
      .col_in  (start_col_i),
      .ilv_in  (ilv_i),
      .mask_in (d_mask),
      .page_in (d_page),
      .bad_in  (d_bad),
      .act     (r_act),
      .beat    (r_beat),
      .base    (r_base),
      .mask    (r_mask),
      .ilv     (r_ilv),
      .bad     (r_bad),
      .last    (r_last)
   );

   col_burst_addr #(.COL_W(COL_W)) u_addr (
      .act  (r_act),
      .base (r_base),
      .beat (r_beat),
      .mask (r_mask),
      .ilv  (r_ilv),
      .col  (col_o)
   );

   assign burst_act_o = r_act;
   assign last_beat_o = r_last;
   assign cfg_err_o   = r_act && r_bad;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_act_o |-> (col_o == '0) && !last_beat_o && !cfg_err_o);

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> burst_act_o && (col_o == $past(start_col_i)));

   assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat_o && !start_i) |=> !burst_act_o);

   assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !burst_act_o);

   assert_bad_cfg_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && ilv_i && len_i == LEN_PAGE) |=> cfg_err_o);

   assert_page_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ilv_i && len_i == LEN_PAGE) |=> !last_beat_o);

endmodule

// File: tb/sdram_col_burst_gen_bench.sv
`timescale 1ns/100ps
module sdram_col_burst_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_i = '0;
   logic       ilv_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       burst_act_o, last_beat_o, cfg_err_o;

   int vectors = 0;
   int misses  = 0;
   string req = "R1";

   // reference model state
   bit m_act = 0;
   int m_k = 0, m_base = 0, m_len = 1;
   bit m_ilv = 0, m_err = 0;

   always #2.5 clk = ~clk;

   sdram_col_burst_gen u_sdram_col_burst_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_i(len_i), .ilv_i(ilv_i), .stop_i(stop_i), .col_o(col_o),
      .burst_act_o(burst_act_o), .last_beat_o(last_beat_o), .cfg_err_o(cfg_err_o));

   // beats for a code; 0 means full page
   function automatic int beats(input int code, input bit ilv);
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         7: return ilv ? 8 : 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col();
      if (!m_act) return 0;
      if (m_len == 0) return (m_base + m_k) % 256;
      if (m_ilv) return m_base ^ m_k;
      return (m_base / m_len) * m_len + ((m_base + m_k) % m_len);
   endfunction

   function automatic bit exp_last();
      return m_act && m_len != 0 && m_k == m_len - 1;
   endfunction

   task automatic compare();
      int ec;
      ec = exp_col();
      vectors++;
      if (col_o !== 8'(ec) || burst_act_o !== m_act || last_beat_o !== exp_last()
          || cfg_err_o !== (m_act && m_err)) begin
         misses++;
         $display("FAIL %s: col/act/last/err = %0h/%0b/%0b/%0b, expected %0h/%0b/%0b/%0b",
                  req, col_o, burst_act_o, last_beat_o, cfg_err_o,
                  ec, m_act, exp_last(), m_act && m_err);
      end
   endtask

   task automatic step(input bit s, input int c, input int l, input bit i, input bit p);
      @(negedge clk);
      start_i = s; start_col_i = 8'(c); len_i = 3'(l); ilv_i = i; stop_i = p;
      @(posedge clk);
      if (s) begin
         m_act = 1; m_k = 0; m_base = c; m_len = beats(l, i);
         m_ilv = i; m_err = (l == 7) && i;
      end else if (p) begin
         m_act = 0;
      end else if (m_act) begin
         if (exp_last()) m_act = 0;
         else m_k = (m_k + 1) % 256;
      end
      #1 compare();
   endtask

   task automatic idle(input int n);
      for (int j = 0; j < n; j++) step(0, 0, 0, 0, 0);
   endtask

   task automatic burst(input int c, input int l, input bit i);
      step(1, c, l, i, 0);
      idle(beats(l, i) + 1);
   endtask

   initial begin
      #(200000 * 5);
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      req = "R1"; compare();
      idle(2);
      // R2 R3 R4: sequential, aligned and unaligned
      req = "R4"; burst(8'h2D, 3, 0);
      burst(8'h40, 3, 0);
      req = "R3"; burst(8'h11, 0, 0);
      burst(8'h13, 1, 0);
      burst(8'hFE, 2, 0);
      req = "R2"; burst(8'hA7, 2, 0);
      // R5: interleave
      req = "R5"; burst(8'h06, 2, 1);
      burst(8'h13, 3, 1);
      burst(8'hFF, 1, 1);
      // R6: full page across the wrap, then R7 stop
      req = "R6"; step(1, 8'hFC, 7, 0, 0); idle(10);
      req = "R7"; step(0, 0, 0, 0, 1); idle(2);
      req = "R6"; step(1, 8'h05, 7, 0, 0); idle(300);
      req = "R7"; step(0, 0, 0, 0, 1); idle(1);
      step(1, 8'h31, 3, 0, 0); idle(3); step(0, 0, 0, 0, 1); idle(2);
      // R8: interruptions on first, middle and last beats
      req = "R8"; step(1, 8'h20, 3, 0, 0); step(1, 8'h55, 2, 1, 0); idle(2);
      step(1, 8'h60, 1, 0, 0); step(0, 0, 0, 0, 0); step(1, 8'h9A, 3, 0, 1); idle(9);
      for (int j = 0; j < 12; j++) step(1, j * 37, j % 4, j[0], 0);
      idle(9);
      // R9: illegal combination
      req = "R9"; burst(8'h7B, 7, 1);
      step(1, 8'h7B, 7, 1, 0); idle(3); step(1, 8'h10, 0, 0, 0); idle(2);
      // R10: reserved codes
      req = "R10"; burst(8'h44, 4, 0); burst(8'h45, 5, 1); burst(8'h46, 6, 0);
      // R11: stop while idle
      req = "R11"; step(0, 8'h12, 3, 1, 1); step(0, 0, 0, 0, 1); idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule